// File: doc/BRIEF.md
# Master clock divider and start-up sequencer

This block runs from the master clock and derives the enables that pace the converter datapath. The master clock is either 256 or 384 times the sample rate. In the 384x case the block drops one cycle out of every three, so the downstream logic always sees a 256fs enable stream. A second enable at half that rate paces the modulator at 128fs.

The block also sequences start-up. While the active-low power-down input is low, everything is held in reset, the output-enable flag is low and the sample data sent downstream is forced to zero. After release, the block waits until the master clock has run for a warm-up interval and the word clock has toggled twice within the activity window. It then waits for a rising word clock edge, which sets the phase of the internal timing, and starts running.

If the word clock stops for a full window, the block drops out of the running state and waits for clocks again. The clock-rate selection takes effect only through a new power-down pulse.

Top module: `mclk_startup`

## Requirements
- R1: While pd_n is low, out_en, en_256 and en_128 are low and dout is zero, without waiting for a clock edge.
- R2: cfg_384 is captured on the first mclk edge after pd_n rises. A later change has no effect on the enable pattern until the next power-down pulse.
- R3: With cfg_384 low at capture, en_256 is high on every mclk cycle while out_en is high.
- R4: With cfg_384 high at capture, en_256 follows the pattern high, high, low, repeating from the first cycle out_en is high. This gives two enables per three master cycles.
- R5: en_128 is high on the first en_256 of the running period and then on every second en_256. It is never high without en_256.
- R6: The block leaves the waiting state only when two conditions hold. At least 16 mclk cycles must have passed since release, and two word clock edges must have been seen with less than 1024 mclk cycles between consecutive edges.
- R7: After the waiting state, out_en rises exactly three mclk cycles after the first mclk edge that samples the word clock high following a low. A falling word clock edge never starts the running state.
- R8: 1024 mclk cycles without a word clock edge drop out_en. The block then needs two new edges and a rising edge before it runs again.
- R9: dout equals din while out_en is high and is zero otherwise.
- R10: out_en is high only in the running state. en_256 and en_128 are low whenever out_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256fs or 384fs |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| cfg_384 | input | 1 | Rate select: 0 = 256fs master, 1 = 384fs master |
| wclk | input | 1 | Word (sample-rate) clock, sampled on mclk |
| din | input | DW (18) | Sample data from the serial input stage |
| en_256 | output | 1 | Internal 256fs timing enable |
| en_128 | output | 1 | 128fs modulator-rate enable |
| out_en | output | 1 | High while running; outputs are driven only then |
| dout | output | DW (18) | Sample data passed downstream, zero unless running |

## Verification
The hardest state to reach from the ports is the waiting state with the warm-up met and the word clock already high. Only there can a falling edge be shown not to start the run. The bench produces it by sending rise, fall and rise edges before the 16-cycle warm-up ends, then drives a fall and checks that out_en stays low. A second hard case is an edge pair that straddles the activity window. The bench gives one edge, lets 1100 cycles pass, and then shows that two further edges are needed before alignment can happen.

// File: rtl/mclk_startup.sv
`timescale 1ns/1ps
module mclk_startup #(
  parameter int DW       = 18,
  parameter int LOSS_CYC = 1024,
  parameter int WARM_CYC = 16
) (
  input  logic          mclk,
  input  logic          pd_n,
  input  logic          cfg_384,
  input  logic          wclk,
  input  logic [DW-1:0] din,
  output logic          en_256,
  output logic          en_128,
  output logic          out_en,
  output logic [DW-1:0] dout
);
  localparam int GW = $clog2(LOSS_CYC);
  localparam int WW = $clog2(WARM_CYC + 1);

  typedef enum logic [1:0] {ST_RESET, ST_WAIT, ST_ALIGN, ST_RUN} st_t;

  st_t          st;
  logic         sel_q;
  logic [2:0]   wsh;
  logic [GW-1:0] gap;
  logic [1:0]   nedge;
  logic [WW-1:0] warm;
  logic [1:0]   ph;
  logic         half;

  wire run     = (st == ST_RUN);
  wire w_edge  = wsh[1] ^ wsh[2];
  wire w_rise  = wsh[1] & ~wsh[2];
  wire lost    = !w_edge && (gap == GW'(LOSS_CYC - 1));
  wire mclk_ok = (warm == WW'(WARM_CYC));
  wire wclk_ok = (nedge == 2'd2);

  assign en_256 = run && (!sel_q || ph != 2'd2);
  assign en_128 = en_256 && !half;
  assign out_en = run;
  assign dout   = run ? din : '0;

  always_ff @(posedge mclk or negedge pd_n) begin
    if (!pd_n) begin
      wsh   <= '0;
      gap   <= '0;
      nedge <= '0;
      warm  <= '0;
    end else begin
      wsh <= {wsh[1:0], wclk};
      gap <= (w_edge || lost) ? '0 : gap + 1'b1;
      if (lost)
        nedge <= '0;
      else if (w_edge && !wclk_ok)
        nedge <= nedge + 1'b1;
      if (!mclk_ok)
        warm <= warm + 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge pd_n) begin
    if (!pd_n) begin
      st    <= ST_RESET;
      sel_q <= 1'b0;
    end else begin
      if (st == ST_RESET)
        sel_q <= cfg_384;
      unique case (st)
        ST_RESET: st <= ST_WAIT;
        ST_WAIT:  if (mclk_ok && wclk_ok) st <= ST_ALIGN;
        ST_ALIGN: if (lost) st <= ST_WAIT;
                  else if (w_rise) st <= ST_RUN;
        ST_RUN:   if (lost) st <= ST_WAIT;
        default:  st <= ST_RESET;
      endcase
    end
  end

  always_ff @(posedge mclk or negedge pd_n) begin
    if (!pd_n) begin
      ph   <= '0;
      half <= 1'b0;
    end else if (!run) begin
      ph   <= '0;
      half <= 1'b0;
    end else begin
      ph <= (ph == 2'd2) ? 2'd0 : ph + 1'b1;
      if (en_256)
        half <= ~half;
    end
  end
endmodule

// File: rtl/mclk_startup_chk.sv
`timescale 1ns/1ps
module mclk_startup_chk #(
  parameter int DW = 18
) (
  input logic          mclk,
  input logic          pd_n,
  input logic          wclk,
  input logic          sel_q,
  input logic          out_en,
  input logic          en_256,
  input logic          en_128,
  input logic [DW-1:0] dout
);
  assert_quiet_idle_R10: assert property (@(posedge mclk) disable iff (!pd_n)
    !out_en |-> (!en_256 && !en_128));

  assert_half_rate_sub_R5: assert property (@(posedge mclk) disable iff (!pd_n)
    en_128 |-> en_256);

  assert_no_three_in_row_R4: assert property (@(posedge mclk) disable iff (!pd_n)
    (sel_q && out_en && $past(en_256) && $past(en_256, 2)) |-> !en_256);

  assert_sel_held_R2: assert property (@(posedge mclk) disable iff (!pd_n)
    (out_en && $past(out_en)) |-> $stable(sel_q));

  assert_zero_data_R9: assert property (@(posedge mclk) disable iff (!pd_n)
    !out_en |-> (dout == '0));

  assert_align_rise_R7: assert property (@(posedge mclk) disable iff (!pd_n)
    $rose(out_en) |-> ($past(wclk, 3) && !$past(wclk, 4)));
endmodule

bind mclk_startup mclk_startup_chk #(.DW(DW)) u_chk (
  .mclk(mclk), .pd_n(pd_n), .wclk(wclk), .sel_q(sel_q),
  .out_en(out_en), .en_256(en_256), .en_128(en_128), .dout(dout)
);

// File: tb/sim_mclk_startup.sv
`timescale 1ns/1ps
module sim_mclk_startup;
  localparam int DW = 18;

  logic          mclk = 1'b0;
  logic          pd_n = 1'b0;
  logic          cfg_384 = 1'b0;
  logic          wclk = 1'b0;
  logic [DW-1:0] din = 18'h2A5C3;
  logic          en_256, en_128, out_en;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;

  mclk_startup #(.DW(DW)) u0 (
    .mclk(mclk), .pd_n(pd_n), .cfg_384(cfg_384), .wclk(wclk), .din(din),
    .en_256(en_256), .en_128(en_128), .out_en(out_en), .dout(dout)
  );

  always #10 mclk = ~mclk;

  // {sel, run cycles, expected en_256 count, expected en_128 count}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 8'd12, 8'd12, 8'd6},
    {8'd1, 8'd12, 8'd8,  8'd4},
    {8'd1, 8'd9,  8'd6,  8'd3},
    {8'd0, 8'd7,  8'd7,  8'd4},
    {8'd1, 8'd7,  8'd5,  8'd3},
    {8'd1, 8'd2,  8'd2,  8'd1}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk);
      @(negedge mclk);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic release_pd(input bit sel);
    pd_n = 1'b0;
    cfg_384 = sel;
    wclk = 1'b0;
    tick(3);
    pd_n = 1'b1;
  endtask

  task automatic bring_up(input bit sel);
    release_pd(sel);
    tick(3);
    wclk = 1'b1;
    tick(5);
    wclk = 1'b0;
    tick(20);
    chk(out_en == 1'b0, "R6 no run before aligning edge", int'(out_en), 0);
    wclk = 1'b1;
    tick(2);
    chk(out_en == 1'b0, "R7 run not yet two cycles after rise", int'(out_en), 0);
    tick(1);
    chk(out_en == 1'b1, "R7 run three cycles after rise", int'(out_en), 1);
  endtask

  task automatic count_en(input int n, output int c256, output int c128);
    c256 = 0;
    c128 = 0;
    for (int i = 0; i < n; i++) begin
      if (en_256) c256++;
      if (en_128) c128++;
      if (dout != din) begin
        chk(1'b0, "R9 dout follows din while running", int'(dout), int'(din));
      end
      tick(1);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b;
    @(negedge mclk);
    tick(2);
    chk(out_en == 1'b0 && en_256 == 1'b0 && en_128 == 1'b0, "R1 reset outputs", int'(out_en), 0);
    chk(dout == '0, "R1 R9 reset data zero", int'(dout), 0);

    for (int v = 0; v < 6; v++) begin
      bring_up(VEC[v][24]);
      count_en(int'(VEC[v][23:16]), a, b);
      chk(a == int'(VEC[v][15:8]),
          VEC[v][24] ? "R4 en_256 count 384fs" : "R3 en_256 count 256fs",
          a, int'(VEC[v][15:8]));
      chk(b == int'(VEC[v][7:0]), "R5 en_128 count", b, int'(VEC[v][7:0]));
    end

    // R2: selection change while running has no effect
    bring_up(1'b0);
    cfg_384 = 1'b1;
    tick(1);
    count_en(12, a, b);
    chk(a == 12, "R2 late select ignored", a, 12);
    bring_up(1'b1);
    cfg_384 = 1'b0;
    tick(1);
    count_en(12, a, b);
    chk(a == 8, "R2 late select ignored 384", a, 8);

    // R1: asynchronous power-down while running
    pd_n = 1'b0;
    #1;
    chk(out_en == 1'b0 && en_256 == 1'b0 && en_128 == 1'b0, "R1 async power-down", int'(out_en), 0);
    chk(dout == '0, "R1 data zero in power-down", int'(dout), 0);
    #1;

    // R6 R7: edges before warm-up, then falling edge must not align
    @(negedge mclk);
    release_pd(1'b0);
    tick(2); wclk = 1'b1;
    tick(2); wclk = 1'b0;
    tick(2); wclk = 1'b1;
    tick(6);
    chk(out_en == 1'b0, "R6 warm-up gates start", int'(out_en), 0);
    tick(10);
    wclk = 1'b0;
    tick(8);
    chk(out_en == 1'b0, "R7 falling edge does not align", int'(out_en), 0);
    wclk = 1'b1;
    tick(3);
    chk(out_en == 1'b1, "R7 rising edge aligns", int'(out_en), 1);

    // R8: word clock loss
    tick(1000);
    chk(out_en == 1'b1, "R8 still running inside window", int'(out_en), 1);
    tick(100);
    chk(out_en == 1'b0, "R8 loss drops run", int'(out_en), 0);
    chk(dout == '0, "R9 data zero after loss", int'(dout), 0);
    wclk = 1'b0; tick(5);
    wclk = 1'b1; tick(5);
    chk(out_en == 1'b0, "R8 two edges alone do not run", int'(out_en), 0);
    wclk = 1'b0; tick(5);
    wclk = 1'b1; tick(3);
    chk(out_en == 1'b1, "R8 recovery after new edges", int'(out_en), 1);

    // R6: edges further apart than the window do not pair up
    release_pd(1'b0);
    tick(20);
    wclk = 1'b1;
    tick(1100);
    wclk = 1'b0; tick(10);
    wclk = 1'b1; tick(5);
    chk(out_en == 1'b0, "R6 stale edge not counted", int'(out_en), 0);
    wclk = 1'b0; tick(5);
    wclk = 1'b1; tick(3);
    chk(out_en == 1'b1, "R6 run after fresh pair", int'(out_en), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule